// File: doc/BRIEF.md
# Shared Interrupt Source Controller

This block takes a parameterised set of external interrupt lines and turns them into per-processor request pins. Software configures each source through a 32-bit word-addressed register port. The per-source settings are sense polarity, level or edge triggering, both-edge capture, an enable (mask) bit, a destination pin and a destination processor. Polarity, trigger, dual-edge, mask and pending state are packed one bit per source, 32 sources to a word.

Edge sources latch into a pending bit. Software acknowledges that bit, or sets it to post an inter-processor interrupt, through a single write-only register that carries the source number. Level sources follow the synchronised input directly. A read-only word reports how many sources and processors the instance was built with. Each processor has `N_PIN` request outputs. A pin is raised while any source routed to it is pending and enabled.

Top module: `shrd_irq_ctrl`

## Requirements
- R1: The mask is changed only through two write-only words: enable-set at word 40 and enable-clear at word 48, with source s at bit s%32 of word base+s/32. A 1 bit enables or disables that source, and 0 bits leave the other sources unchanged. The mask reads back at word 32 with 1 = enabled.
- R2: The per-source settings are polarity (word 8, 1 = active low), trigger (word 16, 1 = edge) and dual-edge (word 24, 1 = both edges). Each is read/write and packed with source s at bit s%32 of word base+s/32.
- R3: A level-triggered source is pending exactly while its input, after two synchroniser flops, is at its active level. Its latched edge bit has no effect on it.
- R4: An edge-triggered source with dual-edge off latches pending on a rising input edge when active high, or on a falling edge when active low. It stays pending after the input returns until software clears it.
- R5: An edge-triggered source with dual-edge on latches pending on both input transitions, whatever its polarity bit.
- R6: A write to the edge word (word 1) with bit 31 = 1 sets, and with bit 31 = 0 clears, the latched edge bit of the source numbered in bits [7:0]. A number at or above N_SRC changes nothing.
- R7: The pending word (word 56) reads the effective pending state of each source: the latched bit for edge sources and the live qualified input for level sources.
- R8: The pin map of source s is at word 64+s. It holds the pin number in bits [PW-1:0] and a valid flag in bit 31. A source whose valid flag is 0 drives no pin.
- R9: The processor map of source s is at word 64+N_SRC+s, one bit per processor. irq_o[c*N_PIN+p] is high exactly when some source is pending, enabled, has bit c set in its processor map, and has a valid pin map selecting p.
- R10: Word 0 is read-only. It reads N_SRC/8-1 in bits [7:0], N_CPU-1 in bits [15:8] and zero elsewhere.
- R11: After reset every source is disabled, active high, level-triggered, dual-edge off, not latched, mapped to no pin and to no processor. All request outputs are low.
- R12: rd_data_o shows the addressed word on the cycle after rd_en_i and holds it otherwise. Unmapped words read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| rd_en_i | input | 1 | Register read strobe |
| addr_i | input | AW (7) | Word address |
| wr_data_i | input | 32 | Write data |
| src_i | input | N_SRC (32) | Asynchronous interrupt inputs |
| rd_data_o | output | 32 | Read data, one cycle after rd_en_i |
| irq_o | output | N_CPU*N_PIN (16) | Request pins, index c*N_PIN+p |

## Verification
The bench goes after the boundary between the latched and the live pending paths. It flips a source between level and edge while its latch holds a software-posted edge, so a design that consulted the latch for level sources would show a stale request. It drives falling edges on active-low and dual-edge sources, where a design that ignored polarity, or applied it under dual-edge, would miss or invent pending bits. It also writes out-of-range source numbers to the edge word and single-bit set/clear masks, where a decoder that aliased the number or rewrote the whole mask word would disturb unrelated sources.

// File: rtl/shrd_irq_pkg.sv
package shrd_irq_pkg;
  // word addresses of register groups; each word group spans up to 8 words
  localparam int unsigned A_CFG  = 0;
  localparam int unsigned A_EDGE = 1;
  localparam int unsigned A_POL  = 8;
  localparam int unsigned A_TRIG = 16;
  localparam int unsigned A_DUAL = 24;
  localparam int unsigned A_MASK = 32;
  localparam int unsigned A_MSET = 40;
  localparam int unsigned A_MCLR = 48;
  localparam int unsigned A_PEND = 56;
  localparam int unsigned A_PIN  = 64;   // then processor maps at A_PIN+N_SRC

  localparam int unsigned EDGE_SET_BIT = 31;
  localparam int unsigned EDGE_NUM_W   = 8;
  localparam int unsigned PIN_VLD_BIT  = 31;
endpackage

// File: rtl/shrd_irq_regs.sv
module shrd_irq_regs
  import shrd_irq_pkg::*;
#(
  parameter int N_SRC = 32,
  parameter int N_CPU = 4,
  parameter int N_PIN = 4,
  parameter int AW    = 7,
  localparam int PW    = $clog2(N_PIN),
  localparam int NWORD = (N_SRC + 31) / 32,
  localparam int PADW  = NWORD * 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic             rd_en_i,
  input  logic [AW-1:0]    addr_i,
  input  logic [31:0]      wr_data_i,
  input  logic [N_SRC-1:0] pend_i,
  output logic [31:0]      rd_data_o,
  output logic [N_SRC-1:0] pol_o,
  output logic [N_SRC-1:0] trig_o,
  output logic [N_SRC-1:0] dual_o,
  output logic [N_SRC-1:0] mask_o,
  output logic [N_SRC-1:0] pin_vld_o,
  output logic [PW-1:0]    pin_o [N_SRC],
  output logic [N_CPU-1:0] cpu_o [N_SRC],
  output logic [N_SRC-1:0] sw_set_o,
  output logic [N_SRC-1:0] sw_clr_o
);
  localparam logic [31:0] CFG_WORD = {16'h0, 8'(N_CPU - 1), 8'(N_SRC / 8 - 1)};

  logic [31:0]     a;
  logic [31:0]     rd_d;
  logic [PADW-1:0] pol_pad, trig_pad, dual_pad, mask_pad, pend_pad;
  logic            unused_wdata;

  assign a            = 32'(addr_i);
  assign unused_wdata = ^wr_data_i;
  assign pol_pad      = PADW'(pol_o);
  assign trig_pad     = PADW'(trig_o);
  assign dual_pad     = PADW'(dual_o);
  assign mask_pad     = PADW'(mask_o);
  assign pend_pad     = PADW'(pend_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pol_o     <= '0;
      trig_o    <= '0;
      dual_o    <= '0;
      mask_o    <= '0;
      pin_vld_o <= '0;
      for (int s = 0; s < N_SRC; s++) begin
        pin_o[s] <= '0;
        cpu_o[s] <= '0;
      end
    end else if (wr_en_i) begin
      for (int s = 0; s < N_SRC; s++) begin
        if (a == A_POL  + 32'(s / 32)) pol_o[s]  <= wr_data_i[s % 32];
        if (a == A_TRIG + 32'(s / 32)) trig_o[s] <= wr_data_i[s % 32];
        if (a == A_DUAL + 32'(s / 32)) dual_o[s] <= wr_data_i[s % 32];
        if (a == A_MSET + 32'(s / 32) && wr_data_i[s % 32]) mask_o[s] <= 1'b1;
        if (a == A_MCLR + 32'(s / 32) && wr_data_i[s % 32]) mask_o[s] <= 1'b0;
        if (a == A_PIN + 32'(s)) begin
          pin_vld_o[s] <= wr_data_i[PIN_VLD_BIT];
          pin_o[s]     <= wr_data_i[PW-1:0];
        end
        if (a == A_PIN + 32'(N_SRC + s)) cpu_o[s] <= wr_data_i[N_CPU-1:0];
      end
    end
  end

  // edge word: decoded to a one-hot set or clear strobe
  always_comb begin
    sw_set_o = '0;
    sw_clr_o = '0;
    if (wr_en_i && a == A_EDGE) begin
      for (int s = 0; s < N_SRC; s++) begin
        if (wr_data_i[EDGE_NUM_W-1:0] == EDGE_NUM_W'(s)) begin
          if (wr_data_i[EDGE_SET_BIT]) sw_set_o[s] = 1'b1;
          else                         sw_clr_o[s] = 1'b1;
        end
      end
    end
  end

  always_comb begin
    rd_d = '0;
    if (a == A_CFG) rd_d = CFG_WORD;
    for (int w = 0; w < NWORD; w++) begin
      if (a == A_POL  + 32'(w)) rd_d = pol_pad[w*32 +: 32];
      if (a == A_TRIG + 32'(w)) rd_d = trig_pad[w*32 +: 32];
      if (a == A_DUAL + 32'(w)) rd_d = dual_pad[w*32 +: 32];
      if (a == A_MASK + 32'(w)) rd_d = mask_pad[w*32 +: 32];
      if (a == A_PEND + 32'(w)) rd_d = pend_pad[w*32 +: 32];
    end
    for (int s = 0; s < N_SRC; s++) begin
      if (a == A_PIN + 32'(s)) begin
        rd_d[PIN_VLD_BIT] = pin_vld_o[s];
        rd_d[PW-1:0]      = pin_o[s];
      end
      if (a == A_PIN + 32'(N_SRC + s)) rd_d[N_CPU-1:0] = cpu_o[s];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      rd_data_o <= '0;
    else if (rd_en_i) rd_data_o <= rd_d;
  end
endmodule

// File: rtl/shrd_irq_detect.sv
module shrd_irq_detect #(
  parameter int N_SRC = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_SRC-1:0] src_i,
  input  logic [N_SRC-1:0] pol_i,
  input  logic [N_SRC-1:0] trig_i,
  input  logic [N_SRC-1:0] dual_i,
  input  logic [N_SRC-1:0] sw_set_i,
  input  logic [N_SRC-1:0] sw_clr_i,
  output logic [N_SRC-1:0] pend_o
);
  for (genvar g = 0; g < N_SRC; g++) begin : g_src
    logic s1_q, s2_q, s3_q, lat_q, evt;

    // raw-level edge compare, so a polarity write never fakes an edge
    assign evt = trig_i[g] & (dual_i[g] ? (s2_q ^ s3_q)
                                        : (pol_i[g] ? (~s2_q & s3_q) : (s2_q & ~s3_q)));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        s1_q  <= 1'b0;
        s2_q  <= 1'b0;
        s3_q  <= 1'b0;
        lat_q <= 1'b0;
      end else begin
        s1_q  <= src_i[g];
        s2_q  <= s1_q;
        s3_q  <= s2_q;
        lat_q <= (lat_q & ~sw_clr_i[g]) | sw_set_i[g] | evt;
      end
    end

    assign pend_o[g] = trig_i[g] ? lat_q : (s2_q ^ pol_i[g]);
  end
endmodule

// File: rtl/shrd_irq_route.sv
module shrd_irq_route #(
  parameter int N_SRC = 32,
  parameter int N_CPU = 4,
  parameter int N_PIN = 4,
  localparam int PW = $clog2(N_PIN)
) (
  input  logic [N_SRC-1:0]       pend_i,
  input  logic [N_SRC-1:0]       mask_i,
  input  logic [N_SRC-1:0]       pin_vld_i,
  input  logic [PW-1:0]          pin_i [N_SRC],
  input  logic [N_CPU-1:0]       cpu_i [N_SRC],
  output logic [N_CPU*N_PIN-1:0] irq_o
);
  logic [N_SRC-1:0] live;
  assign live = pend_i & mask_i & pin_vld_i;

  always_comb begin
    irq_o = '0;
    for (int s = 0; s < N_SRC; s++)
      for (int c = 0; c < N_CPU; c++)
        for (int p = 0; p < N_PIN; p++)
          if (live[s] && cpu_i[s][c] && pin_i[s] == PW'(p)) irq_o[c*N_PIN+p] = 1'b1;
  end
endmodule

// File: rtl/shrd_irq_ctrl.sv
module shrd_irq_ctrl #(
  parameter int N_SRC = 32,
  parameter int N_CPU = 4,
  parameter int N_PIN = 4,
  localparam int AW = $clog2(shrd_irq_pkg::A_PIN + 2 * N_SRC),
  localparam int PW = $clog2(N_PIN)
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   wr_en_i,
  input  logic                   rd_en_i,
  input  logic [AW-1:0]          addr_i,
  input  logic [31:0]            wr_data_i,
  input  logic [N_SRC-1:0]       src_i,
  output logic [31:0]            rd_data_o,
  output logic [N_CPU*N_PIN-1:0] irq_o
);
  logic [N_SRC-1:0] pol_w, trig_w, dual_w, mask_w, pin_vld_w, pend_w, sw_set_w, sw_clr_w;
  logic [PW-1:0]    pin_w [N_SRC];
  logic [N_CPU-1:0] cpu_w [N_SRC];

  shrd_irq_regs #(.N_SRC(N_SRC), .N_CPU(N_CPU), .N_PIN(N_PIN), .AW(AW)) u_regs (
    .clk_i, .rst_ni, .wr_en_i, .rd_en_i, .addr_i, .wr_data_i,
    .pend_i(pend_w), .rd_data_o,
    .pol_o(pol_w), .trig_o(trig_w), .dual_o(dual_w), .mask_o(mask_w),
    .pin_vld_o(pin_vld_w), .pin_o(pin_w), .cpu_o(cpu_w),
    .sw_set_o(sw_set_w), .sw_clr_o(sw_clr_w)
  );

  shrd_irq_detect #(.N_SRC(N_SRC)) u_detect (
    .clk_i, .rst_ni, .src_i,
    .pol_i(pol_w), .trig_i(trig_w), .dual_i(dual_w),
    .sw_set_i(sw_set_w), .sw_clr_i(sw_clr_w), .pend_o(pend_w)
  );

  shrd_irq_route #(.N_SRC(N_SRC), .N_CPU(N_CPU), .N_PIN(N_PIN)) u_route (
    .pend_i(pend_w), .mask_i(mask_w), .pin_vld_i(pin_vld_w),
    .pin_i(pin_w), .cpu_i(cpu_w), .irq_o
  );
endmodule

// File: rtl/shrd_irq_ctrl_chk.sv
module shrd_irq_ctrl_chk #(
  parameter int N_SRC = 32,
  parameter int N_CPU = 4,
  parameter int N_PIN = 4,
  parameter int AW    = 7
) (
  input logic                   clk_i,
  input logic                   rst_ni,
  input logic                   wr_en_i,
  input logic                   rd_en_i,
  input logic [AW-1:0]          addr_i,
  input logic [31:0]            wr_data_i,
  input logic [31:0]            rd_data_o,
  input logic [N_CPU*N_PIN-1:0] irq_o,
  input logic [N_SRC-1:0]       mask_w,
  input logic [N_SRC-1:0]       pin_vld_w
);
  localparam int LW = (N_SRC < 32) ? N_SRC : 32;
  localparam logic [31:0] CFG = {16'h0, 8'(N_CPU - 1), 8'(N_SRC / 8 - 1)};

  assert_mask_set_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_i == AW'(shrd_irq_pkg::A_MSET)) |=>
      mask_w[LW-1:0] == ($past(mask_w[LW-1:0]) | $past(wr_data_i[LW-1:0])));

  assert_mask_clr_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_i == AW'(shrd_irq_pkg::A_MCLR)) |=>
      mask_w[LW-1:0] == ($past(mask_w[LW-1:0]) & ~$past(wr_data_i[LW-1:0])));

  assert_cfg_read_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && addr_i == AW'(shrd_irq_pkg::A_CFG)) |=> rd_data_o == CFG);

  assert_rd_hold_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_en_i |=> $stable(rd_data_o));

  assert_masked_quiet_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mask_w == '0) |-> (irq_o == '0));

  assert_no_pin_quiet_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pin_vld_w == '0) |-> (irq_o == '0));
endmodule

bind shrd_irq_ctrl shrd_irq_ctrl_chk #(.N_SRC(N_SRC), .N_CPU(N_CPU), .N_PIN(N_PIN), .AW(AW)) u_chk (
  .clk_i, .rst_ni, .wr_en_i, .rd_en_i, .addr_i, .wr_data_i, .rd_data_o, .irq_o,
  .mask_w, .pin_vld_w
);

// File: tb/tb_shrd_irq_ctrl.sv
module tb_shrd_irq_ctrl;
  localparam int N = 32, NC = 4, NP = 4, AW = 7;
  localparam int W_CFG = 0, W_EDGE = 1, W_POL = 8, W_TRIG = 16, W_DUAL = 24,
                 W_MASK = 32, W_MSET = 40, W_MCLR = 48, W_PEND = 56, W_PIN = 64, W_CPU = 96;

  logic clk = 0, rst_n = 0, wr_en = 0, rd_en = 0;
  logic [AW-1:0] addr = '0;
  logic [31:0] wdata = '0, rdata;
  logic [N-1:0] src = '0;
  logic [NC*NP-1:0] irq;

  always #10 clk = ~clk;

  shrd_irq_ctrl dut (.clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .rd_en_i(rd_en),
    .addr_i(addr), .wr_data_i(wdata), .src_i(src), .rd_data_o(rdata), .irq_o(irq));

  int errors = 0, checks = 0;
  logic [N-1:0] m_pol = '0, m_trig = '0, m_dual = '0, m_mask = '0, m_lat = '0, m_pv = '0;
  logic [1:0]  m_pin [N];
  logic [NC-1:0] m_cpu [N];

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    @(negedge clk); wr_en = 1; addr = AW'(a); wdata = d;
    @(negedge clk); wr_en = 0;
    case (a)
      W_POL:  m_pol  = d;
      W_TRIG: m_trig = d;
      W_DUAL: m_dual = d;
      W_MSET: m_mask = m_mask | d;
      W_MCLR: m_mask = m_mask & ~d;
      W_EDGE: if (d[7:0] < N) m_lat[d[7:0]] = d[31];
      default: begin
        if (a >= W_PIN && a < W_PIN + N) begin m_pv[a-W_PIN] = d[31]; m_pin[a-W_PIN] = d[1:0]; end
        if (a >= W_CPU && a < W_CPU + N) m_cpu[a-W_CPU] = d[NC-1:0];
      end
    endcase
  endtask

  task automatic rd(input int a, output logic [31:0] d);
    @(negedge clk); rd_en = 1; addr = AW'(a);
    @(negedge clk); rd_en = 0; d = rdata;
  endtask

  task automatic drive_src(input logic [N-1:0] v);
    for (int s = 0; s < N; s++) begin
      if (m_trig[s] && src[s] != v[s]) begin
        if (m_dual[s]) m_lat[s] = 1'b1;
        else if (m_pol[s] ? (src[s] && !v[s]) : (!src[s] && v[s])) m_lat[s] = 1'b1;
      end
    end
    @(negedge clk); src = v;
    repeat (4) @(negedge clk);
  endtask

  function automatic logic [N-1:0] exp_pend();
    for (int s = 0; s < N; s++) exp_pend[s] = m_trig[s] ? m_lat[s] : (src[s] ^ m_pol[s]);
  endfunction

  function automatic logic [NC*NP-1:0] exp_irq();
    logic [N-1:0] p = exp_pend();
    exp_irq = '0;
    for (int s = 0; s < N; s++)
      if (p[s] && m_mask[s] && m_pv[s])
        for (int c = 0; c < NC; c++) if (m_cpu[s][c]) exp_irq[c*NP + m_pin[s]] = 1'b1;
  endfunction

  task automatic check_all(input string tag);
    logic [31:0] d;
    chk(32'(irq), 32'(exp_irq()), {tag, " irq R9"});
    rd(W_PEND, d); chk(d, exp_pend(), {tag, " pending R7"});
    rd(W_MASK, d); chk(d, m_mask, {tag, " mask R1"});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [31:0] d;
    void'($urandom(32'd1234));
    for (int s = 0; s < N; s++) begin m_pin[s] = '0; m_cpu[s] = '0; end
    repeat (3) @(negedge clk);
    rst_n = 1;

    // R11 reset state, R10 config
    chk(32'(irq), 0, "R11 irq after reset");
    rd(W_CFG, d);  chk(d, 32'h0000_0303, "R10 config word");
    rd(W_MASK, d); chk(d, 0, "R11 mask reset");
    rd(W_POL, d);  chk(d, 0, "R11 polarity reset");
    rd(W_TRIG, d); chk(d, 0, "R11 trigger reset");
    rd(W_PEND, d); chk(d, 0, "R11 pending reset");
    rd(W_PIN + 5, d); chk(d, 0, "R11 pin map reset");
    rd(W_CPU + 5, d); chk(d, 0, "R11 cpu map reset");
    wr(W_CFG, 32'hFFFF_FFFF);
    rd(W_CFG, d);  chk(d, 32'h0000_0303, "R10 config read-only");
    rd(2, d);      chk(d, 0, "R12 unmapped word");

    // R3 level routing: src3 -> cpu2 pin1
    wr(W_PIN + 3, 32'h8000_0001); wr(W_CPU + 3, 32'h4); wr(W_MSET, 32'h8);
    drive_src(32'h8);
    chk(32'(irq), 32'h0000_0200, "R3 level high raises cpu2 pin1");
    drive_src(32'h0);
    chk(32'(irq), 0, "R3 level drops with input");
    wr(W_POL, 32'h8);
    chk(32'(irq), 32'h0000_0200, "R3 active-low idle input requests");
    wr(W_POL, 32'h0);
    wr(W_PIN + 3, 32'h0000_0001);
    drive_src(32'h8);
    chk(32'(irq), 0, "R8 invalid pin drives nothing");
    wr(W_PIN + 3, 32'h8000_0001);
    drive_src(32'h0);

    // R4 rising edge latches
    wr(W_TRIG, 32'h8);
    drive_src(32'h8); drive_src(32'h0);
    chk(32'(irq), 32'h0000_0200, "R4 edge held after input falls");
    check_all("R4 rising");
    wr(W_EDGE, 32'h0000_0003);
    chk(32'(irq), 0, "R6 clear acknowledges edge");
    // R4 active low: only falling edge latches
    wr(W_POL, 32'h8);
    drive_src(32'h8);
    chk(32'(irq), 0, "R4 active-low rising ignored");
    drive_src(32'h0);
    chk(32'(irq), 32'h0000_0200, "R4 active-low falling latches");
    wr(W_EDGE, 32'h0000_0003);
    // R5 dual edge, polarity ignored
    wr(W_DUAL, 32'h8);
    drive_src(32'h8);
    chk(32'(irq), 32'h0000_0200, "R5 dual rising latches");
    wr(W_EDGE, 32'h0000_0003);
    drive_src(32'h0);
    chk(32'(irq), 32'h0000_0200, "R5 dual falling latches");
    wr(W_EDGE, 32'h0000_0003);
    // R6 software set, out-of-range number
    wr(W_EDGE, 32'h8000_0028);
    rd(W_PEND, d); chk(d, 0, "R6 out-of-range number ignored");
    wr(W_EDGE, 32'h8000_0003);
    chk(32'(irq), 32'h0000_0200, "R6 software set posts edge");
    // R3 latch unused in level mode
    wr(W_TRIG, 32'h0); wr(W_DUAL, 32'h0); wr(W_POL, 32'h0);
    chk(32'(irq), 0, "R3 level ignores latched edge");
    // R1 single-bit mask ops
    wr(W_MSET, 32'hF0F0_0000); wr(W_MCLR, 32'h1000_0000);
    rd(W_MASK, d); chk(d, 32'hE0F0_0008, "R1 set/clear bitwise");
    // R2 readback
    wr(W_DUAL, 32'hA5A5_0F0F);
    rd(W_DUAL, d); chk(d, 32'hA5A5_0F0F, "R2 dual readback");
    wr(W_DUAL, 32'h0);

    // random
    for (int i = 0; i < 400; i++) begin
      int op = $urandom_range(0, 8);
      int s  = $urandom_range(0, N - 1);
      case (op)
        0: wr(W_POL + 0, $urandom());
        1: wr(W_TRIG, $urandom());
        2: wr(W_DUAL, $urandom());
        3: wr($urandom_range(0, 1) ? W_MSET : W_MCLR, $urandom());
        4: wr(W_EDGE, {$urandom_range(0, 1) == 1, 23'h0, 8'($urandom_range(0, 40))});
        5: wr(W_PIN + s, {$urandom_range(0, 3) != 0, 29'h0, 2'($urandom_range(0, 3))});
        6: wr(W_CPU + s, 32'(4'(1 << $urandom_range(0, NC - 1))));
        default: drive_src($urandom());
      endcase
      repeat (3) @(negedge clk);
      check_all("random R2 R5 R4");
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule